// File: doc/BRIEF.md
# Microcode Sequencer with Flag-Tested Branching

This block runs the microcode of one machine instruction. An instruction controller presents a start address and raises a start request. The sequencer then reads microcode words from an internal synchronous ROM, one per cycle, and drives each word's control field straight to the datapath as enables and multiplexer selects. No further decoding happens after the sequencer. A word can redirect the microcode program counter, either by a jump or by a branch that tests one of eight status flags. When a word carries the end-of-instruction marker, the sequencer stops and pulses a completion strobe.

A bus-controller busy input freezes the sequencer. While it is high, the program counter, the word being executed and the control output all hold. Branch and jump words reuse the low bits of the control field as their target address, so these words always put an all-zero control pattern on the output. A synchronous ROM read means that a taken redirect costs one empty cycle, and that cycle also outputs all zeros. The ROM image is a parameter, built by whoever instantiates the block.

Top module: `useq_top`

## Requirements
- R1: While reset is high and after it is released, `ctrl_o` is all zeros, `done_o` is 0 and `busy_o` is 0 until a start request is accepted.
- R2: A change on `start_addr_i` without `start_i` starts nothing. When `start_i` is seen high in the idle state, the word at `start_addr_i` drives `ctrl_o` in the cycle after that edge, and `busy_o` is 1 from that cycle on.
- R3: The word layout, from the MSB down, is: end marker (1 bit), type (2 bits), condition (3 bits), control (`CTRL_W` bits). When a word neither ends nor redirects, the next cycle executes the word at the following address, one word per cycle with no gap.
- R4: Suppose a word with the end marker set executes in cycle n, with the busy input low. Then `done_o` is 1 in cycle n+1 only, and from cycle n+1 `ctrl_o` is zero and `busy_o` is 0. The end marker takes priority over the word's type.
- R5: While `mem_busy_i` is high during a run, `ctrl_o` and the program counter hold. Sequencing resumes with the following word in the cycle after the input falls.
- R6: A type 01 word branches when the flag picked by its condition field is set. The flag index in `flags_i` equals the code: 0 parity, 1 carry, 2 overflow, 3 zero, 4 negative, 5 interrupt, 6 half-carry, 7 supervisor. A taken branch is followed by one all-zero cycle, and then by the word at the target held in the low `ADDR_W` control bits. A branch that is not taken goes on to the next address with no gap.
- R7: A type 10 word jumps to its target whatever the flags are, with the same single empty cycle.
- R8: Branch and jump words drive `ctrl_o` to all zeros, even when their control field is nonzero.
- R9: A type 11 word behaves exactly like a type 00 (normal) word, and its control field reaches `ctrl_o`.
- R10: A start request that arrives while `busy_o` is 1 is ignored, and the running sequence goes on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request from the instruction controller |
| start_addr_i | input | ADDR_W | Microcode entry address, captured with the start request |
| flags_i | input | 8 | Status flags tested by branch words |
| mem_busy_i | input | 1 | Bus controller busy; stalls sequencing |
| ctrl_o | output | CTRL_W | Control word to the datapath |
| done_o | output | 1 | One-cycle completion strobe |
| busy_o | output | 1 | Sequencer is running or stalled |

## Verification
Each of the eight condition codes is exercised twice. In the first run only the tested flag is set, so the branch must be taken. In the second run every other flag is set, so it must fall through. Together these runs separate a correct flag mapping from any permuted or inverted one, and they also check the bubble and the gap-free fall-through. A straight-line sequence, and a jump with all flags clear that lands on a type 11 word, separate sequential stepping from redirection and normal from reserved handling. Directed runs then check three more things: a stall in the middle of the sequence, a start request during a run, and an address change with no start request. These runs show that the held state and the ignored inputs leave the sequence of control words unchanged.

// File: rtl/useq_pkg.sv
package useq_pkg;

   localparam int FLAG_COUNT = 8;
   localparam int COND_BITS  = 3;
   localparam int TYPE_BITS  = 2;

   typedef enum logic [TYPE_BITS-1:0] {
      WT_NORMAL = 2'b00,
      WT_BRANCH = 2'b01,
      WT_JUMP   = 2'b10,
      WT_SPARE  = 2'b11
   } wtype_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_RUN  = 2'b01,
      ST_WAIT = 2'b10
   } seq_state_e;

   // flag positions inside the status vector; condition code equals index
   localparam int FLG_PARITY   = 0;
   localparam int FLG_CARRY    = 1;
   localparam int FLG_OVERFLOW = 2;
   localparam int FLG_ZERO     = 3;
   localparam int FLG_NEGATIVE = 4;
   localparam int FLG_INTR     = 5;
   localparam int FLG_HALF     = 6;
   localparam int FLG_SUPER    = 7;

endpackage

// File: rtl/useq_rom.sv
module useq_rom #(
   parameter int ADDR_W = 10,
   parameter int WORD_W = 54,
   parameter int DEPTH  = 1 << ADDR_W,
   parameter logic [DEPTH*WORD_W-1:0] IMAGE = '0
) (
   input  logic              clk,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data
);

   if (DEPTH > (1 << ADDR_W)) begin : g_depth_bad
      $error("useq_rom: DEPTH exceeds address range");
   end

   logic [WORD_W-1:0] words [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_unpack
      assign words[i] = IMAGE[i*WORD_W +: WORD_W];
   end

   always_ff @(posedge clk) begin
      if (rd_en) begin
         rd_data <= words[rd_addr];
      end
   end

endmodule

// File: rtl/useq_cond.sv
module useq_cond
   import useq_pkg::*;
(
   input  logic [FLAG_COUNT-1:0] flags,
   input  logic [COND_BITS-1:0]  cond,
   input  wtype_e                wtype,
   output logic                  redirect_req
);

   logic flag_hit;

   always_comb begin
      flag_hit = flags[cond];
      unique case (wtype)
         WT_JUMP:   redirect_req = 1'b1;
         WT_BRANCH: redirect_req = flag_hit;
         default:   redirect_req = 1'b0;
      endcase
   end

endmodule

// File: rtl/useq_seq.sv
module useq_seq
   import useq_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic              mem_busy_i,
   input  logic              word_last,
   input  logic              redirect_req,
   input  logic [ADDR_W-1:0] target,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              word_valid,
   output logic              redirect,
   output logic              active,
   output logic              done
);

   localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

   seq_state_e        state_q;
   logic [ADDR_W-1:0] pc_q;
   logic              valid_q;
   logic              done_q;
   logic              advance;
   logic              exec;
   logic              finish;
   logic              accept;

   always_comb begin
      active   = (state_q != ST_IDLE);
      accept   = (state_q == ST_IDLE) && start_i;
      advance  = active && !mem_busy_i;
      exec     = advance && valid_q;
      finish   = exec && word_last;
      redirect = exec && !word_last && redirect_req;
      rd_en    = accept || (advance && !finish && !redirect);
      rd_addr  = accept ? start_addr_i : pc_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         pc_q    <= '0;
         valid_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= finish;
         if (state_q == ST_IDLE) begin
            if (start_i) begin
               pc_q    <= start_addr_i + ADDR_ONE;
               valid_q <= 1'b1;
               state_q <= ST_RUN;
            end
         end else if (mem_busy_i) begin
            state_q <= ST_WAIT;
         end else if (finish) begin
            state_q <= ST_IDLE;
            valid_q <= 1'b0;
         end else if (redirect) begin
            state_q <= ST_RUN;
            pc_q    <= target;
            valid_q <= 1'b0;
         end else begin
            state_q <= ST_RUN;
            pc_q    <= pc_q + ADDR_ONE;
            valid_q <= 1'b1;
         end
      end
   end

   assign word_valid = valid_q;
   assign done       = done_q;

   assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
      done_q |=> !done_q);

   assert_hold_pc_R5: assert property (@(posedge clk) disable iff (rst)
      (active && mem_busy_i) |=> ($stable(pc_q) && $stable(valid_q)));

   assert_seq_step_R3: assert property (@(posedge clk) disable iff (rst)
      (exec && !word_last && !redirect_req) |=> (pc_q == ADDR_W'($past(pc_q) + ADDR_ONE)));

   assert_redirect_load_R6: assert property (@(posedge clk) disable iff (rst)
      redirect |=> (pc_q == $past(target) && !valid_q && active));

   assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
      (active && start_i && mem_busy_i) |=> $stable(pc_q));

endmodule

// File: rtl/useq_top.sv
module useq_top
   import useq_pkg::*;
#(
   parameter int CTRL_W = 48,
   parameter int ADDR_W = 10,
   parameter int DEPTH  = 1 << ADDR_W,
   parameter int WORD_W = CTRL_W + TYPE_BITS + COND_BITS + 1,
   parameter logic [DEPTH*WORD_W-1:0] ROM_IMAGE = '0
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  start_i,
   input  logic [ADDR_W-1:0]     start_addr_i,
   input  logic [FLAG_COUNT-1:0] flags_i,
   input  logic                  mem_busy_i,
   output logic [CTRL_W-1:0]     ctrl_o,
   output logic                  done_o,
   output logic                  busy_o
);

   localparam int COND_LSB = CTRL_W;
   localparam int TYPE_LSB = CTRL_W + COND_BITS;
   localparam int LAST_BIT = CTRL_W + COND_BITS + TYPE_BITS;

   if (ADDR_W < 8 || ADDR_W > 12) begin : g_addr_bad
      $error("useq_top: ADDR_W must lie in 8..12");
   end
   if (CTRL_W < ADDR_W) begin : g_ctrl_bad
      $error("useq_top: CTRL_W must hold a target address");
   end
   if (WORD_W != LAST_BIT + 1) begin : g_word_bad
      $error("useq_top: WORD_W does not match field layout");
   end

   logic [WORD_W-1:0] word_q;
   logic              rd_en;
   logic [ADDR_W-1:0] rd_addr;
   logic              word_valid;
   logic              redirect_req;
   logic              redirect;
   logic              active;
   wtype_e            wtype;

   assign wtype = wtype_e'(word_q[TYPE_LSB +: TYPE_BITS]);

   useq_rom #(
      .ADDR_W (ADDR_W),
      .WORD_W (WORD_W),
      .DEPTH  (DEPTH),
      .IMAGE  (ROM_IMAGE)
   ) u_rom (
      .clk     (clk),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .rd_data (word_q)
   );

   useq_cond u_cond (
      .flags        (flags_i),
      .cond         (word_q[COND_LSB +: COND_BITS]),
      .wtype        (wtype),
      .redirect_req (redirect_req)
   );

   useq_seq #(
      .ADDR_W (ADDR_W)
   ) u_seq (
      .clk          (clk),
      .rst          (rst),
      .start_i      (start_i),
      .start_addr_i (start_addr_i),
      .mem_busy_i   (mem_busy_i),
      .word_last    (word_q[LAST_BIT]),
      .redirect_req (redirect_req),
      .target       (word_q[ADDR_W-1:0]),
      .rd_en        (rd_en),
      .rd_addr      (rd_addr),
      .word_valid   (word_valid),
      .redirect     (redirect),
      .active       (active),
      .done         (done_o)
   );

   always_comb begin
      if (word_valid && (wtype == WT_NORMAL || wtype == WT_SPARE)) begin
         ctrl_o = word_q[CTRL_W-1:0];
      end else begin
         ctrl_o = '0;
      end
   end

   assign busy_o = active;

   assert_done_idle_R4: assert property (@(posedge clk) disable iff (rst)
      done_o |-> (!busy_o && ctrl_o == '0));

   assert_stall_ctrl_R5: assert property (@(posedge clk) disable iff (rst)
      (busy_o && mem_busy_i) |=> $stable(ctrl_o));

   assert_redirect_quiet_R8: assert property (@(posedge clk) disable iff (rst)
      redirect |-> (ctrl_o == '0));

   assert_bubble_zero_R6: assert property (@(posedge clk) disable iff (rst)
      redirect |=> (ctrl_o == '0));

   assert_reset_state_R1: assert property (@(posedge clk)
      rst |=> (!busy_o && !done_o));

endmodule

// File: tb/tb_useq_top.sv
module tb_useq_top;

   localparam int CLK_PERIOD = 10;
   localparam int CTRL_W = 48;
   localparam int ADDR_W = 10;
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int WORD_W = CTRL_W + 6;
   localparam logic [10:0] ZV = 11'h400;

   function automatic logic [CTRL_W-1:0] ctrl_of(input logic [9:0] a);
      return {6'h2B, a, 16'hBEEF, a, ~a[5:0]};
   endfunction

   function automatic logic [WORD_W-1:0] mkw(input logic last, input logic [1:0] ty,
                                             input logic [2:0] cd, input logic [CTRL_W-1:0] c);
      return {last, ty, cd, c};
   endfunction

   function automatic logic [CTRL_W-1:0] tgt(input logic [9:0] a);
      return {{(CTRL_W-ADDR_W){1'b1}}, a};
   endfunction

   function automatic logic [DEPTH*WORD_W-1:0] build_image();
      logic [DEPTH*WORD_W-1:0] img;
      img = '0;
      img[16'h010*WORD_W +: WORD_W] = mkw(1'b0, 2'b00, 3'd0, ctrl_of(10'h010));
      img[16'h011*WORD_W +: WORD_W] = mkw(1'b0, 2'b00, 3'd6, ctrl_of(10'h011));
      img[16'h012*WORD_W +: WORD_W] = mkw(1'b1, 2'b00, 3'd0, ctrl_of(10'h012));
      img[16'h030*WORD_W +: WORD_W] = mkw(1'b0, 2'b10, 3'd0, tgt(10'h050));
      img[16'h050*WORD_W +: WORD_W] = mkw(1'b0, 2'b00, 3'd0, ctrl_of(10'h050));
      img[16'h051*WORD_W +: WORD_W] = mkw(1'b1, 2'b11, 3'd5, ctrl_of(10'h051));
      for (int c = 0; c < 8; c++) begin
         int b = 'h100 + 4*c;
         int t = 'h200 + c;
         img[b*WORD_W +: WORD_W]     = mkw(1'b0, 2'b00, 3'(c), ctrl_of(10'(b)));
         img[(b+1)*WORD_W +: WORD_W] = mkw(1'b0, 2'b01, 3'(c), tgt(10'(t)));
         img[(b+2)*WORD_W +: WORD_W] = mkw(1'b1, 2'b00, 3'd0, ctrl_of(10'(b+2)));
         img[t*WORD_W +: WORD_W]     = mkw(1'b1, 2'b00, 3'd0, ctrl_of(10'(t)));
      end
      return img;
   endfunction

   localparam logic [DEPTH*WORD_W-1:0] IMG = build_image();

   typedef struct packed {
      logic [9:0]  sa;
      logic [7:0]  fl;
      logic [10:0] e1, e2, e3, e4, e5;
      logic [2:0]  dc;
   } vec_t;

   localparam vec_t VECS [18] = '{
      '{10'h010, 8'h00, 11'h010, 11'h011, 11'h012, ZV, ZV, 3'd4},
      '{10'h030, 8'h00, ZV, ZV, 11'h050, 11'h051, ZV, 3'd5},
      '{10'h100, 8'h01, 11'h100, ZV, ZV, 11'h200, ZV, 3'd5},
      '{10'h100, 8'hFE, 11'h100, ZV, 11'h102, ZV, ZV, 3'd4},
      '{10'h104, 8'h02, 11'h104, ZV, ZV, 11'h201, ZV, 3'd5},
      '{10'h104, 8'hFD, 11'h104, ZV, 11'h106, ZV, ZV, 3'd4},
      '{10'h108, 8'h04, 11'h108, ZV, ZV, 11'h202, ZV, 3'd5},
      '{10'h108, 8'hFB, 11'h108, ZV, 11'h10A, ZV, ZV, 3'd4},
      '{10'h10C, 8'h08, 11'h10C, ZV, ZV, 11'h203, ZV, 3'd5},
      '{10'h10C, 8'hF7, 11'h10C, ZV, 11'h10E, ZV, ZV, 3'd4},
      '{10'h110, 8'h10, 11'h110, ZV, ZV, 11'h204, ZV, 3'd5},
      '{10'h110, 8'hEF, 11'h110, ZV, 11'h112, ZV, ZV, 3'd4},
      '{10'h114, 8'h20, 11'h114, ZV, ZV, 11'h205, ZV, 3'd5},
      '{10'h114, 8'hDF, 11'h114, ZV, 11'h116, ZV, ZV, 3'd4},
      '{10'h118, 8'h40, 11'h118, ZV, ZV, 11'h206, ZV, 3'd5},
      '{10'h118, 8'hBF, 11'h118, ZV, 11'h11A, ZV, ZV, 3'd4},
      '{10'h11C, 8'h80, 11'h11C, ZV, ZV, 11'h207, ZV, 3'd5},
      '{10'h11C, 8'h7F, 11'h11C, ZV, 11'h11E, ZV, ZV, 3'd4}
   };

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              start_i = 1'b0;
   logic [ADDR_W-1:0] start_addr_i = '0;
   logic [7:0]        flags_i = '0;
   logic              mem_busy_i = 1'b0;
   logic [CTRL_W-1:0] ctrl_o;
   logic              done_o;
   logic              busy_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   useq_top #(
      .CTRL_W    (CTRL_W),
      .ADDR_W    (ADDR_W),
      .ROM_IMAGE (IMG)
   ) dut (
      .clk          (clk),
      .rst          (rst),
      .start_i      (start_i),
      .start_addr_i (start_addr_i),
      .flags_i      (flags_i),
      .mem_busy_i   (mem_busy_i),
      .ctrl_o       (ctrl_o),
      .done_o       (done_o),
      .busy_o       (busy_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [CTRL_W-1:0] exp_of(input logic [10:0] code);
      return (code == ZV) ? '0 : ctrl_of(code[9:0]);
   endfunction

   function automatic logic [10:0] pick(input vec_t v, input int k);
      case (k)
         1: return v.e1;
         2: return v.e2;
         3: return v.e3;
         4: return v.e4;
         5: return v.e5;
         default: return ZV;
      endcase
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   // raise start on a falling edge; returns at the sample point of cycle 1
   task automatic launch(input logic [ADDR_W-1:0] a);
      @(negedge clk);
      start_i = 1'b1;
      start_addr_i = a;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD*20000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", {63'd0, busy_o}, 64'd0);
      check("R1", {16'd0, ctrl_o}, 64'd0);
      rst = 1'b0;
      @(negedge clk);
      check("R1", {62'd0, busy_o, done_o}, 64'd0);

      // R2: address change alone starts nothing
      start_addr_i = 10'h010;
      repeat (3) begin
         @(negedge clk);
         check("R2", {16'd0, ctrl_o}, 64'd0);
         check("R2", {63'd0, busy_o}, 64'd0);
      end

      // table walk: R3 sequence, R7/R9 jump, R6/R8 branches
      for (int i = 0; i < 18; i++) begin
         string tag;
         flags_i = VECS[i].fl;
         launch(VECS[i].sa);
         check("R2", {63'd0, busy_o}, 64'd1);
         for (int k = 1; k <= 6; k++) begin
            if (i == 0) tag = "R3";
            else if (i == 1) tag = (k == 1) ? "R8" : (k == 4) ? "R9" : "R7";
            else tag = (k == 2) ? "R8" : "R6";
            check(tag, {16'd0, ctrl_o}, {16'd0, exp_of(pick(VECS[i], k))});
            check("R4", {63'd0, done_o}, {63'd0, (k == int'(VECS[i].dc))});
            @(negedge clk);
         end
         check("R4", {63'd0, busy_o}, 64'd0);
      end

      // R5: stall in mid-sequence
      flags_i = '0;
      launch(10'h010);
      check("R5", {16'd0, ctrl_o}, {16'd0, ctrl_of(10'h010)});
      mem_busy_i = 1'b1;
      repeat (3) begin
         @(negedge clk);
         check("R5", {16'd0, ctrl_o}, {16'd0, ctrl_of(10'h010)});
         check("R5", {63'd0, done_o}, 64'd0);
      end
      mem_busy_i = 1'b0;
      @(negedge clk);
      check("R5", {16'd0, ctrl_o}, {16'd0, ctrl_of(10'h011)});
      @(negedge clk);
      check("R5", {16'd0, ctrl_o}, {16'd0, ctrl_of(10'h012)});
      @(negedge clk);
      check("R5", {63'd0, done_o}, 64'd1);
      repeat (2) @(negedge clk);

      // R10: start during a run is ignored
      launch(10'h010);
      check("R10", {16'd0, ctrl_o}, {16'd0, ctrl_of(10'h010)});
      start_i = 1'b1;
      start_addr_i = 10'h030;
      @(negedge clk);
      start_i = 1'b0;
      check("R10", {16'd0, ctrl_o}, {16'd0, ctrl_of(10'h011)});
      @(negedge clk);
      check("R10", {16'd0, ctrl_o}, {16'd0, ctrl_of(10'h012)});
      @(negedge clk);
      check("R10", {63'd0, done_o}, 64'd1);
      @(negedge clk);
      check("R10", {16'd0, ctrl_o}, 64'd0);
      check("R4", {63'd0, done_o}, 64'd0);

      report();
   end

endmodule